// File: doc/BRIEF.md
# Doppler Sweep Carrier Phase Generator

This block drives a carrier numerically controlled oscillator across a list of Doppler hypotheses within a single acquisition run. A launch pulse captures a signed starting phase increment, a signed increment step, a sweep count and a per-sweep sample count. During each sweep the block holds one phase increment and advances a 32-bit phase accumulator once for every sample accepted on a valid/ready handshake. When a sweep has taken its full number of samples, the accumulator returns to zero, the increment grows by the step, and the sweep index moves on.

The phase increment is a signed Q1.31 fraction of pi radians per sample: +2^31 stands for +pi and -2^31 for -pi. Software derives the start value from twice the lowest Doppler frequency over the sample rate, and the step from twice the Doppler spacing over the sample rate. The phase word feeds a sine/cosine lookup further down the chain. The sweep index is the value reported as the Doppler index of the winning peak. A one-cycle done pulse marks the end of the run.

Top module: `doppler_sweep_nco`

## Requirements
- R1: While reset is low and on the cycle after it, busy, done and sample ready are 0, and phase, sweep index and current increment are 0.
- R2: A launch pulse taken while idle, with nonzero sweep and sample counts, captures the configuration. On the next cycle busy and ready are 1, the phase is 0, the sweep index is 0 and the current increment equals the start increment.
- R3: Each sample accepted while busy and not the last of its sweep advances the phase by the current increment modulo 2^32. The phase holds when valid is low.
- R4: The accept of the final sample of a sweep that is not the last clears the phase to 0 and raises the sweep index by one. The index counts from 0 up to the sweep count minus 1.
- R5: The increment used in sweep k equals the start increment plus k times the step, in two's complement modulo 2^32. Positive steps may wrap into negative values.
- R6: The accept of the final sample of the last sweep makes done 1 for exactly one cycle. On that cycle busy and ready drop to 0 and the sweep index holds at the sweep count minus 1.
- R7: A launch pulse while busy is ignored. The run continues with the captured start increment, step and counts, and its phase, index and increment sequence is unchanged.
- R8: A launch with a sweep count or sample count of zero produces a done pulse on the next cycle, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| launch | input | 1 | Start a run (accepted only when idle) |
| cfg_inc_start | input | 32 | Signed Q1.31 increment for sweep 0 |
| cfg_inc_step | input | 32 | Signed Q1.31 increment added per sweep |
| cfg_sweeps | input | 8 | Number of sweeps in the run |
| cfg_samples | input | 16 | Samples per sweep |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_ready | output | 1 | Block accepts samples (high while busy) |
| phase | output | 32 | Phase word for the current sample |
| cur_inc | output | 32 | Increment of the current sweep |
| sweep_idx | output | 8 | Index of the current sweep |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |

## Verification
On every cycle the assertions check that the phase holds without valid and advances by exactly the increment on an accept. They also check the phase clear, the index step and the increment step at each sweep boundary, and that done is a single-cycle pulse with busy low. The bench scenarios cover what needs a whole-run reference: the increment sequence across a signed wrap, the held final index, a launch ignored mid-run while a different configuration is applied, and zero-count launches.

// File: rtl/dsn_pkg.sv
// Package: shared widths and types for the Doppler sweep phase generator.
// Assumes two's complement arithmetic throughout.
package dsn_pkg;
    localparam int PH_W  = 32;
    localparam int SWP_W = 8;
    localparam int SMP_W = 16;
    typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/dsn_sequencer.sv
// Module: run sequencer. Counts accepted samples and sweeps and produces
// the load, sweep-advance and done strobes. Assumes launch is ignored while busy.
module dsn_sequencer #(
    parameter int SWP_W = 8,
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [SWP_W-1:0] cfg_sweeps,
    input  logic [SMP_W-1:0] cfg_samples,
    input  logic             smp_valid,
    output logic             busy,
    output logic             load,
    output logic             accept,
    output logic             sweep_end,
    output logic             sweep_adv,
    output logic             done,
    output logic [SWP_W-1:0] sweep_idx
);
    logic             busy_q, done_q;
    logic [SWP_W-1:0] sweeps_q, idx_q;
    logic [SMP_W-1:0] samples_q, cnt_q;
    logic             zero_cfg, last_sweep, run_end;

    // Strobe decode for the current cycle
    always_comb begin
        zero_cfg   = (cfg_sweeps == '0) || (cfg_samples == '0);
        load       = launch && !busy_q && !zero_cfg;
        accept     = busy_q && smp_valid;
        sweep_end  = accept && (cnt_q == samples_q - SMP_W'(1));
        last_sweep = (idx_q == sweeps_q - SWP_W'(1));
        sweep_adv  = sweep_end && !last_sweep;
        run_end    = sweep_end && last_sweep;
    end

    // Run state, configuration capture and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            sweeps_q  <= '0;
            samples_q <= '0;
            idx_q     <= '0;
            cnt_q     <= '0;
        end else begin
            done_q <= run_end || (launch && !busy_q && zero_cfg);
            if (load) begin
                busy_q    <= 1'b1;
                sweeps_q  <= cfg_sweeps;
                samples_q <= cfg_samples;
                idx_q     <= '0;
                cnt_q     <= '0;
            end else if (run_end) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else if (sweep_adv) begin
                idx_q <= idx_q + SWP_W'(1);
                cnt_q <= '0;
            end else if (accept) begin
                cnt_q <= cnt_q + SMP_W'(1);
            end
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign sweep_idx = idx_q;
endmodule

// File: rtl/dsn_inc_gen.sv
// Module: increment generator. Holds the per-sweep phase increment and adds
// the captured signed step at each sweep advance. Wraps modulo 2^PH_W.
module dsn_inc_gen #(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            sweep_adv,
    input  logic [PH_W-1:0] cfg_inc_start,
    input  logic [PH_W-1:0] cfg_inc_step,
    output logic [PH_W-1:0] inc,
    output logic [PH_W-1:0] step
);
    logic [PH_W-1:0] inc_q, step_q;

    // Capture on load, step on sweep advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q  <= '0;
            step_q <= '0;
        end else if (load) begin
            inc_q  <= cfg_inc_start;
            step_q <= cfg_inc_step;
        end else if (sweep_adv) begin
            inc_q <= inc_q + step_q;
        end
    end

    assign inc  = inc_q;
    assign step = step_q;
endmodule

// File: rtl/dsn_phase_acc.sv
// Module: phase accumulator. Adds the increment per accepted sample and
// clears at the start of every sweep. Wraps modulo 2^PH_W.
module dsn_phase_acc #(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            accept,
    input  logic [PH_W-1:0] inc,
    output logic [PH_W-1:0] phase
);
    logic [PH_W-1:0] acc_q;

    // Clear has priority over accumulation
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clear)  acc_q <= '0;
        else if (accept) acc_q <= acc_q + inc;
    end

    assign phase = acc_q;
endmodule

// File: rtl/doppler_sweep_nco.sv
// Module: top of the Doppler sweep phase generator. Wires the sequencer,
// increment generator and phase accumulator. Assumes one sample per accept.
module doppler_sweep_nco #(
    parameter int PH_W  = dsn_pkg::PH_W,
    parameter int SWP_W = dsn_pkg::SWP_W,
    parameter int SMP_W = dsn_pkg::SMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [PH_W-1:0]  cfg_inc_start,
    input  logic [PH_W-1:0]  cfg_inc_step,
    input  logic [SWP_W-1:0] cfg_sweeps,
    input  logic [SMP_W-1:0] cfg_samples,
    input  logic             smp_valid,
    output logic             smp_ready,
    output logic [PH_W-1:0]  phase,
    output logic [PH_W-1:0]  cur_inc,
    output logic [SWP_W-1:0] sweep_idx,
    output logic             busy,
    output logic             done
);
    logic            load, accept, sweep_end, sweep_adv;
    logic [PH_W-1:0] step_q;

    dsn_sequencer #(.SWP_W(SWP_W), .SMP_W(SMP_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .cfg_sweeps(cfg_sweeps), .cfg_samples(cfg_samples),
        .smp_valid(smp_valid), .busy(busy), .load(load), .accept(accept),
        .sweep_end(sweep_end), .sweep_adv(sweep_adv), .done(done),
        .sweep_idx(sweep_idx)
    );

    dsn_inc_gen #(.PH_W(PH_W)) inc_i (
        .clk(clk), .rst_n(rst_n), .load(load), .sweep_adv(sweep_adv),
        .cfg_inc_start(cfg_inc_start), .cfg_inc_step(cfg_inc_step),
        .inc(cur_inc), .step(step_q)
    );

    dsn_phase_acc #(.PH_W(PH_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .clear(load || sweep_end),
        .accept(accept), .inc(cur_inc), .phase(phase)
    );

    assign smp_ready = busy;
endmodule

// File: rtl/dsn_checker.sv
// Module: property checker for doppler_sweep_nco, attached by bind.
module dsn_checker #(
    parameter int PH_W  = 32,
    parameter int SWP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             busy,
    input logic             done,
    input logic             accept,
    input logic             sweep_end,
    input logic             sweep_adv,
    input logic             load,
    input logic [PH_W-1:0]  phase,
    input logic [PH_W-1:0]  cur_inc,
    input logic [PH_W-1:0]  step_q,
    input logic [SWP_W-1:0] sweep_idx
);
    // R1: reset leaves the block idle
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !busy && !done && phase == '0);
    // R2: load starts a run at phase 0, sweep 0
    a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy && phase == '0 && sweep_idx == '0);
    // R3: phase holds without valid
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !smp_valid) |=> $stable(phase));
    // R3: phase advances by the increment on an accept inside a sweep
    a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sweep_end) |=> phase == $past(phase) + $past(cur_inc));
    // R4: sweep advance clears phase and bumps the index
    a_r4_sweep_adv: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_adv |=> phase == '0 && sweep_idx == $past(sweep_idx) + SWP_W'(1));
    // R5: increment grows by the step at sweep advance
    a_r5_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_adv |=> cur_inc == $past(cur_inc) + $past(step_q));
    // R6: end of run raises done with busy low, for one cycle
    a_r6_run_end: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_end && !sweep_adv) |=> done && !busy);
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: increment is stable within a sweep
    a_r7_inc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sweep_adv && !load) |=> $stable(cur_inc));
endmodule

bind doppler_sweep_nco dsn_checker #(.PH_W(PH_W), .SWP_W(SWP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .busy(busy),
    .done(done), .accept(accept), .sweep_end(sweep_end),
    .sweep_adv(sweep_adv), .load(load), .phase(phase), .cur_inc(cur_inc),
    .step_q(step_q), .sweep_idx(sweep_idx)
);

// File: tb/doppler_sweep_nco_tb.sv
// Directed bench for doppler_sweep_nco: one task per scenario.
module doppler_sweep_nco_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch = 1'b0;
    logic [31:0] cfg_inc_start = '0, cfg_inc_step = '0;
    logic [7:0]  cfg_sweeps = '0;
    logic [15:0] cfg_samples = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, busy, done;
    logic [31:0] phase, cur_inc;
    logic [7:0]  sweep_idx;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    doppler_sweep_nco dut_i (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .cfg_inc_start(cfg_inc_start), .cfg_inc_step(cfg_inc_step),
        .cfg_sweeps(cfg_sweeps), .cfg_samples(cfg_samples),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .phase(phase),
        .cur_inc(cur_inc), .sweep_idx(sweep_idx), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 0 && smp_ready == 0, "R1 busy/ready", {busy, smp_ready}, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(phase == 0 && cur_inc == 0, "R1 phase/inc", phase | cur_inc, 0);
        chk(sweep_idx == 0, "R1 idx", sweep_idx, 0);
    endtask

    // Full run with model; gap>0 drops valid every gap-th cycle; inj launches mid-run
    task automatic t_run(input logic [31:0] st, input logic [31:0] sp, input int nsw,
                         input int nsm, input int gap, input bit inj, input string tag);
        logic [31:0] e_ph, e_inc;
        int e_idx, cnt, cyc;
        bit fin, v;
        @(negedge clk);
        cfg_inc_start = st; cfg_inc_step = sp;
        cfg_sweeps = 8'(nsw); cfg_samples = 16'(nsm); launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        chk(busy == 1 && smp_ready == 1, {"R2 busy ", tag}, busy, 1);
        e_ph = 0; e_inc = st; e_idx = 0; cnt = 0; cyc = 0; fin = 0;
        while (!fin) begin
            chk(phase == e_ph, {"R3 phase ", tag}, phase, e_ph);
            chk(cur_inc == e_inc, {"R5 inc ", tag}, cur_inc, e_inc);
            chk(sweep_idx == 8'(e_idx), {"R4 idx ", tag}, sweep_idx, e_idx);
            chk(busy == 1, {"R7 busy ", tag}, busy, 1);
            v = (gap == 0) || (cyc % gap != 0);
            smp_valid = v;
            launch = 1'b0;
            if (inj && cyc == 3) begin
                launch = 1'b1;
                cfg_inc_start = 32'h1234_5678; cfg_inc_step = 32'h0000_0011;
                cfg_sweeps = 8'd1; cfg_samples = 16'd2;
            end
            @(negedge clk);
            cyc++;
            if (v) begin
                e_ph = e_ph + e_inc;
                cnt++;
                if (cnt == nsm) begin
                    cnt = 0; e_ph = 0;
                    if (e_idx == nsw - 1) fin = 1;
                    else begin e_idx++; e_inc = e_inc + sp; end
                end
            end
        end
        smp_valid = 1'b0; launch = 1'b0;
        chk(done == 1, {"R6 done ", tag}, done, 1);
        chk(busy == 0 && smp_ready == 0, {"R6 busy ", tag}, busy, 0);
        chk(sweep_idx == 8'(nsw - 1), {"R6 idx ", tag}, sweep_idx, nsw - 1);
        @(negedge clk);
        chk(done == 0, {"R6 pulse ", tag}, done, 0);
    endtask

    task automatic t_zero(input int nsw, input int nsm, input string tag);
        @(negedge clk);
        cfg_sweeps = 8'(nsw); cfg_samples = 16'(nsm); launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        chk(done == 1, {"R8 done ", tag}, done, 1);
        chk(busy == 0, {"R8 busy ", tag}, busy, 0);
        @(negedge clk);
        chk(done == 0 && busy == 0, {"R8 after ", tag}, {done, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_run(32'd1000, 32'd250, 3, 4, 0, 0, "basic");
        t_run(32'h7FFF_0000, 32'h0002_0000, 4, 5, 3, 0, "wrap");
        t_run(32'hF000_0000, 32'hFFFF_FF00, 2, 6, 0, 1, "launch-busy");
        t_run(32'h0000_4000, 32'd7, 1, 1, 0, 0, "single");
        t_zero(0, 4, "sweeps0");
        t_zero(3, 0, "samples0");
        t_run(32'h4000_0000, 32'hC000_0000, 3, 3, 2, 0, "neg-step");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule